// File: doc/BRIEF.md
# Multi-rate digitally controlled oscillator with holdover

The block is a bank of phase accumulators that stand in for the oscillator of a telecom clock recovery loop. It has one accumulator for each of four output clock families. Those families are nominally 19.44, 25.248, 32.768 and 24.704 MHz, and they serve the C19, C6, E1 and T1 divider paths. Each accumulator adds its own nominal increment plus one shared signed frequency correction on every system clock. When an accumulator wraps, it emits a one-cycle tick enable, and the downstream dividers build their clocks from these ticks.

A mode input picks where the correction comes from:

- **Normal:** the correction is the one most recently delivered by the loop filter.
- **Holdover:** the correction is a history value. That value was captured once per 8 kHz frame while the loop was tracking.
- **Freerun:** the correction is zero, so every output runs at its nominal ratio to the master clock.

A mode change applies from the next clock edge. It never disturbs the accumulator phase.

Top module: `dco_holdover`

## Requirements
- R1: While rst_ni is low, every tick output is 0, every accumulator is 0, the active correction is 0, and both the tracking correction and the holdover history value are 0.
- R2: Mode 0 (normal) uses the tracking correction as the active correction (corr_o). The tracking correction loads corr_i on each clock edge where mode_i is 0 and valid_i is 1, so it appears on corr_o one cycle after it is sampled.
- R3: An internal frame counter runs from 0 to FRAME_DIV-1 and wraps, and its strobe is the cycle in which it holds FRAME_DIV-1. The first strobe is therefore the FRAME_DIV-th rising edge after reset is released. On a strobe edge where mode_i is 0 and valid_i is 1, the holdover history value loads corr_i.
- R4: Mode 1 (holdover) uses the holdover history value as the active correction. While not in mode 0, that history value never changes, whatever valid_i and corr_i do.
- R5: Modes 2 and 3 (freerun) give an active correction of 0, so each inc_o lane equals its nominal increment NOM_INC.
- R6: Each lane's increment is NOM_INC[i] + floor(NOM_INC[i] * corr_o / 2^PPM_SHIFT), taken modulo 2^ACC_W. The correction is signed two's complement.
- R7: On every clock edge, each accumulator advances by its lane's current increment, modulo 2^ACC_W. tick_o[i] is 1 for exactly the cycle after an edge on which that addition carried out of ACC_W bits.
- R8: A mode change does not reset or step any accumulator. Its phase continues from its previous value, using the new increment from the next edge onward.
- R9: Outside mode 0, valid_i is ignored and the tracking correction keeps its value. On returning to mode 0, the last correction taken in mode 0 is used until a new valid arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (master) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 normal, 1 holdover, 2 or 3 freerun |
| valid_i | input | 1 | corr_i carries a new filtered correction |
| corr_i | input | CORR_W | Signed correction from the loop filter |
| tick_o | output | NUM_OUT | One-cycle wrap pulse per output family (index 0 C19, 1 C6, 2 E1, 3 T1) |
| inc_o | output | NUM_OUT x ACC_W | Current increment word of each lane |
| corr_o | output | CORR_W | Active signed correction |

## Verification
On every cycle, the assertions check four things:

- the one-cycle load path from a valid correction to corr_o in normal mode;
- the steadiness of corr_o through an unbroken holdover stay;
- that freerun increments equal the nominal words;
- that the tracking and history registers are frozen outside normal mode.

Other behaviours can only be shown by the bench's scenarios:

- that the captured history value is the one present on the frame strobe;
- the tick timing, since it depends on accumulated phase;
- the scaling of the correction into each lane's increment;
- phase continuity across mode changes.

The bench compares these against a cycle model under directed sequences and random mode, valid and correction traffic.

// File: rtl/dco_pkg.sv
package dco_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_HOLDOVER = 2'd1,
    MODE_FREERUN  = 2'd2,
    MODE_FREERUN2 = 2'd3
  } dco_mode_e;
endpackage

// File: rtl/dco_frame_timer.sv
module dco_frame_timer #(
  parameter int unsigned FRAME_DIV = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  localparam int unsigned CNT_W = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign strobe_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dco_word_sel.sv
module dco_word_sel
  import dco_pkg::*;
#(
  parameter int unsigned CORR_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic                     valid_i,
  input  logic signed [CORR_W-1:0] corr_i,
  input  logic                     frame_i,
  output logic signed [CORR_W-1:0] corr_o,
  output logic signed [CORR_W-1:0] norm_q_o,
  output logic signed [CORR_W-1:0] hold_q_o
);
  logic signed [CORR_W-1:0] norm_q, hold_q;
  logic take;

  assign take = (mode_i == MODE_NORMAL) && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_q <= '0;
      hold_q <= '0;
    end else begin
      if (take)            norm_q <= corr_i;
      if (take && frame_i) hold_q <= corr_i;
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_NORMAL:   corr_o = norm_q;
      MODE_HOLDOVER: corr_o = hold_q;
      default:       corr_o = '0;
    endcase
  end

  assign norm_q_o = norm_q;
  assign hold_q_o = hold_q;
endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned CORR_W    = 16,
  parameter int unsigned PPM_SHIFT = 20,
  parameter logic [ACC_W-1:0] NOM  = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [CORR_W-1:0] corr_i,
  output logic [ACC_W-1:0]         inc_o,
  output logic                     tick_o
);
  localparam int unsigned PROD_W = ACC_W + 1 + CORR_W;

  logic signed [PROD_W-1:0] prod, delta;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  // signed scaling: nom * corr / 2^PPM_SHIFT, floor
  assign prod  = $signed({1'b0, NOM}) * corr_i;
  assign delta = prod >>> PPM_SHIFT;
  assign inc_o = NOM + delta[ACC_W-1:0];
  assign sum   = {1'b0, acc_q} + {1'b0, inc_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_o <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/dco_holdover.sv
module dco_holdover #(
  parameter int unsigned NUM_OUT   = 4,
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned CORR_W    = 16,
  parameter int unsigned PPM_SHIFT = 20,
  parameter int unsigned FRAME_DIV = 25000,
  // lane 0 C19, 1 C6, 2 E1, 3 T1 at a 200 MHz master clock
  parameter logic [NUM_OUT-1:0][ACC_W-1:0] NOM_INC =
    {32'd530514360, 32'd703687442, 32'd542196671, 32'd417470821}
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [1:0]                      mode_i,
  input  logic                            valid_i,
  input  logic signed [CORR_W-1:0]        corr_i,
  output logic [NUM_OUT-1:0]              tick_o,
  output logic [NUM_OUT-1:0][ACC_W-1:0]   inc_o,
  output logic signed [CORR_W-1:0]        corr_o
);
  logic frame_strobe;
  logic signed [CORR_W-1:0] norm_corr_q, hold_corr_q;

  dco_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_o (frame_strobe)
  );

  dco_word_sel #(.CORR_W(CORR_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .valid_i  (valid_i),
    .corr_i   (corr_i),
    .frame_i  (frame_strobe),
    .corr_o   (corr_o),
    .norm_q_o (norm_corr_q),
    .hold_q_o (hold_corr_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    dco_phase_acc #(
      .ACC_W     (ACC_W),
      .CORR_W    (CORR_W),
      .PPM_SHIFT (PPM_SHIFT),
      .NOM       (NOM_INC[g])
    ) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .corr_i (corr_o),
      .inc_o  (inc_o[g]),
      .tick_o (tick_o[g])
    );
  end
endmodule

// File: rtl/dco_holdover_chk.sv
module dco_holdover_chk #(
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned CORR_W  = 16,
  parameter logic [NUM_OUT-1:0][ACC_W-1:0] NOM_INC = '0
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [1:0]                    mode_i,
  input logic                          valid_i,
  input logic signed [CORR_W-1:0]      corr_i,
  input logic signed [CORR_W-1:0]      corr_o,
  input logic [NUM_OUT-1:0][ACC_W-1:0] inc_o,
  input logic signed [CORR_W-1:0]      norm_q,
  input logic signed [CORR_W-1:0]      hold_q
);
  // R2
  norm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == 2'd0 && $past(valid_i) && mode_i == 2'd0)
      |-> corr_o == $past(corr_i));

  // R4
  hold_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == 2'd1 && mode_i == 2'd1) |-> $stable(corr_o));

  // R5
  freerun_nom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> inc_o == NOM_INC);

  // R4
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0) |=> $stable(hold_q));

  // R9
  norm_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0) |=> $stable(norm_q));
endmodule

bind dco_holdover dco_holdover_chk #(
  .NUM_OUT (NUM_OUT),
  .ACC_W   (ACC_W),
  .CORR_W  (CORR_W),
  .NOM_INC (NOM_INC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .valid_i (valid_i),
  .corr_i  (corr_i),
  .corr_o  (corr_o),
  .inc_o   (inc_o),
  .norm_q  (norm_corr_q),
  .hold_q  (hold_corr_q)
);

// File: tb/dco_holdover_tb_top.sv
`timescale 1ns/1ps
module dco_holdover_tb_top;
  localparam int unsigned N  = 4;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 16;
  localparam int unsigned PS = 20;
  localparam int unsigned FD = 20;
  localparam logic [N-1:0][AW-1:0] NOM =
    {32'd530514360, 32'd703687442, 32'd542196671, 32'd417470821};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic valid = 1'b0;
  logic signed [CW-1:0] corr = '0;
  logic [N-1:0] tick;
  logic [N-1:0][AW-1:0] inc;
  logic signed [CW-1:0] corr_act;

  int checks = 0;
  int errors = 0;
  int win = 0;
  int tick_cnt [N];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dco_holdover #(.NUM_OUT(N), .ACC_W(AW), .CORR_W(CW), .PPM_SHIFT(PS),
                 .FRAME_DIV(FD), .NOM_INC(NOM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .valid_i(valid),
    .corr_i(corr), .tick_o(tick), .inc_o(inc), .corr_o(corr_act));

  function automatic logic [AW-1:0] f_inc(logic [AW-1:0] nom, logic signed [CW-1:0] c);
    logic signed [AW+CW:0] p;
    p = $signed({1'b0, nom}) * c;
    p = p >>> PS;
    return nom + p[AW-1:0];
  endfunction

  function automatic logic signed [CW-1:0] f_corr(logic [1:0] md,
      logic signed [CW-1:0] nq, logic signed [CW-1:0] hq);
    if (md == 2'd0) return nq;
    if (md == 2'd1) return hq;
    return '0;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle model
  logic signed [CW-1:0] m_nq, m_hq;
  logic [AW-1:0] m_acc [N];
  logic [N-1:0] m_tick;
  int m_fc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_nq <= '0; m_hq <= '0; m_tick <= '0; m_fc <= 0;
      for (int i = 0; i < N; i++) m_acc[i] <= '0;
    end else begin
      logic signed [CW-1:0] c;
      logic [AW:0] s;
      c = f_corr(mode, m_nq, m_hq);
      for (int i = 0; i < N; i++) begin
        s = {1'b0, m_acc[i]} + {1'b0, f_inc(NOM[i], c)};
        m_acc[i] <= s[AW-1:0];
        m_tick[i] <= s[AW];
      end
      if (mode == 2'd0 && valid) m_nq <= corr;
      if (mode == 2'd0 && valid && m_fc == FD - 1) m_hq <= corr;
      m_fc <= (m_fc == FD - 1) ? 0 : m_fc + 1;
    end
  end

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      chk(tick == '0, "R1 tick", tick, 0);
      chk(corr_act == 0, "R1 corr", corr_act, 0);
    end else if (!done) begin
      logic signed [CW-1:0] ec;
      ec = f_corr(mode, m_nq, m_hq);
      chk(corr_act == ec, mode == 2'd0 ? "R2 corr" : (mode == 2'd1 ? "R4 corr" : "R5 corr"),
          corr_act, ec);
      for (int i = 0; i < N; i++) begin
        chk(inc[i] == f_inc(NOM[i], ec), "R6 inc", inc[i], f_inc(NOM[i], ec));
        chk(tick[i] == m_tick[i], win > 0 ? "R8 tick" : "R7 tick", tick[i], m_tick[i]);
        if (tick[i]) tick_cnt[i]++;
      end
      if (win > 0) win--;
    end
  end

  task automatic drive(logic [1:0] md, logic v, logic signed [CW-1:0] c);
    @(negedge clk);
    if (md != mode) win = 40;
    mode = md; valid = v; corr = c;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "WATCHDOG", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) tick_cnt[i] = 0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R1: history and tracking value are zero after reset
    rst_n = 1'b1;
    mode = 2'd1; valid = 1'b0; corr = '0;
    #1 chk(corr_act == 0, "R1 hold", corr_act, 0);
    @(negedge clk);
    mode = 2'd0;
    #1 chk(corr_act == 0, "R1 norm", corr_act, 0);
    // strobes at model-aligned edges; capture history through mode 0
    for (int k = 1; k <= 2 * FD + 5; k++) drive(2'd0, 1'b1, CW'(k * 3 - 70));
    drive(2'd1, 1'b1, 16'sd999);
    #1 chk(corr_act == m_hq, "R3 capture", corr_act, m_hq);
    begin
      logic signed [CW-1:0] held;
      held = corr_act;
      for (int k = 0; k < 3 * FD; k++) drive(2'd1, 1'b1, CW'($urandom));
      #1 chk(corr_act == held, "R4 frozen", corr_act, held);
    end
    drive(2'd3, 1'b1, 16'sd777);
    #1 chk(inc == NOM, "R5 nominal", 0, 0);
    drive(2'd2, 1'b1, -16'sd5);
    drive(2'd0, 1'b0, 16'sd1);
    #1 chk(corr_act == CW'((2 * FD + 5) * 3 - 70), "R9 keep", corr_act, (2 * FD + 5) * 3 - 70);
    // extremes of the correction range
    drive(2'd0, 1'b1, 16'sh7fff);
    repeat (30) drive(2'd0, 1'b0, 16'sd0);
    drive(2'd0, 1'b1, 16'sh8000);
    repeat (30) drive(2'd0, 1'b0, 16'sd0);
    // random traffic
    begin
      logic [1:0] md;
      md = 2'd0;
      for (int k = 0; k < 6000; k++) begin
        logic signed [CW-1:0] c;
        if ($urandom_range(0, 39) == 0) md = 2'($urandom);
        c = CW'($urandom);
        if ($urandom_range(0, 15) == 0) c = 16'sh7fff;
        if ($urandom_range(0, 15) == 0) c = 16'sh8000;
        drive(md, 1'($urandom), c);
      end
    end
    @(negedge clk);
    done = 1'b1;
    for (int i = 0; i < N; i++) chk(tick_cnt[i] > 0, "R7 ticks seen", tick_cnt[i], 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule